// File: doc/BRIEF.md
# Single Bus Cycle Capture Unit

This unit sits beside the target logic on a 32-bit multiplexed address/data bus and records one transaction for a management controller. The bus uses active-low framing and handshakes. A cycle starts when the framing signal falls: that cycle is the address phase. A data beat completes on any cycle in which both the initiator-ready and target-ready strobes are low. The controller arms the unit. The next address phase that an external window decoder marks as a hit is then recorded: its command code, its address, the byte enables and the data of its first completed beat. The capture-valid flag then rises and stays up until the controller acknowledges the record.

The recorded data depends on the command. For a write it is the value on the bus. For a read it is the value the target returned, which is taken from one of two holding registers chosen by a read-source select. Configuration cycles and unknown commands carry no data. In single-shot mode an acknowledge sends the unit back to idle. In continuous mode it re-arms the unit, and this repeats until the controller cancels. A transaction that is still framed when its first beat completes is a burst. Only that first beat is recorded, and the record is marked as a burst.

The controller state machine has four states: ST_IDLE (disarmed), ST_ARMED (waiting for a hit address phase), ST_DATA (waiting for the first completed beat) and ST_HOLD (record valid). Its transitions are as follows:
- arm moves ST_IDLE to ST_ARMED.
- cancel moves ST_ARMED back to ST_IDLE.
- A hit address phase moves ST_ARMED to ST_DATA.
- A completed beat moves ST_DATA to ST_HOLD.
- An acknowledge moves ST_HOLD to ST_ARMED in continuous mode, and to ST_IDLE otherwise.

Top module: `bus_cycle_capture`

## Requirements
- R1: After reset, armed and cap_valid are 0.
- R2: While not armed, bus cycles are not captured. A one-cycle arm pulse in the idle state sets armed from the next cycle. The sampled cont_mode selects continuous (1) or single-shot (0) operation. armed and cap_valid are never both 1.
- R3: Only an address phase (bus_frame_n low after being high) with tgt_hit=1 starts a capture. An address phase with tgt_hit=0 leaves the unit armed.
- R4: The record holds cap_cmd = bus_cbe_n and cap_addr = bus_ad, both sampled in the address phase. It holds cap_be_n = bus_cbe_n sampled at the first completed beat; these enables are active low, so 4'b1110 enables byte lane 0 only. cap_valid rises in the cycle after that beat.
- R5: For writes (I/O write = 4'h3, memory write = 4'h7), cap_data is bus_ad at the completed beat and cap_data_ok=1.
- R6: For reads (I/O read = 4'h2, memory read = 4'h6), cap_data is wr_reg_q when rd_src_sel=0 and ld_reg_q when rd_src_sel=1, and cap_data_ok=1.
- R7: For configuration reads (4'hA) and writes (4'hB), cap_data_ok=0 and cap_data=0.
- R8: Any other command is still captured, with cap_other=1, cap_data_ok=0 and cap_data=0.
- R9: If bus_frame_n is still low at the first completed beat, cap_burst=1. Later beats do not change the record.
- R10: The record stays unchanged until ack. In single-shot mode, bus cycles during the hold are ignored, and ack returns the unit to idle.
- R11: In continuous mode, ack re-arms the unit and the next hit cycle is captured. cancel ends continuous operation.
- R12: When cancel and a hit address phase fall in the same cycle while armed, cancel wins: the unit disarms and records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm request pulse from the controller |
| cont_mode | input | 1 | Continuous mode select, sampled on arm |
| cancel | input | 1 | Stops continuous mode and disarms |
| ack | input | 1 | Record acknowledge (readout done) |
| rd_src_sel | input | 1 | Read data source: 0 bus-written register, 1 locally loaded register |
| bus_frame_n | input | 1 | Active-low transaction framing |
| bus_irdy_n | input | 1 | Active-low initiator ready |
| bus_trdy_n | input | 1 | Active-low target ready |
| bus_ad | input | 32 | Multiplexed address/data |
| bus_cbe_n | input | 4 | Command (address phase) / active-low byte enables (data phase) |
| tgt_hit | input | 1 | Address decoder hit for this target |
| wr_reg_q | input | 32 | Bus-written data register contents |
| ld_reg_q | input | 32 | Locally loaded data register contents |
| armed | output | 1 | Unit is waiting for a cycle |
| cap_valid | output | 1 | Record is valid |
| cap_cmd | output | 4 | Captured command code |
| cap_addr | output | 32 | Captured address |
| cap_data | output | 32 | Captured data |
| cap_data_ok | output | 1 | cap_data is meaningful |
| cap_be_n | output | 4 | Captured active-low byte enables |
| cap_burst | output | 1 | Transaction was a burst |
| cap_other | output | 1 | Command was not a recognised code |

## Verification
Cancel and the start of a capture can fall in the same cycle. The bench provokes this by raising cancel in exactly the address-phase cycle of a hit transaction while the unit is armed. The outcome is judged at the ports: after the data beat, armed must be 0 and cap_valid must stay 0. A second case lets the acknowledge of a held record in continuous mode coincide with the re-arming path, and then checks that the next hit cycle is recorded with its own fields.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DATA  = 2'd2,
        ST_HOLD  = 2'd3
    } cap_state_t;

    localparam logic [3:0] CMD_IO_RD  = 4'h2;
    localparam logic [3:0] CMD_IO_WR  = 4'h3;
    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    typedef enum logic [1:0] {
        CL_WRITE = 2'd0,
        CL_READ  = 2'd1,
        CL_CFG   = 2'd2,
        CL_OTHER = 2'd3
    } cmd_class_t;

    function automatic cmd_class_t classify(input logic [3:0] c);
        unique case (c)
            CMD_IO_WR, CMD_MEM_WR: classify = CL_WRITE;
            CMD_IO_RD, CMD_MEM_RD: classify = CL_READ;
            CMD_CFG_RD, CMD_CFG_WR: classify = CL_CFG;
            default: classify = CL_OTHER;
        endcase
    endfunction
endpackage

// File: rtl/cap_phase_track.sv
module cap_phase_track (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    output logic addr_phase,
    output logic beat_done
);
    logic frame_n_q;

    always_ff @(posedge clk) begin
        if (!rst_n) frame_n_q <= 1'b1;
        else        frame_n_q <= frame_n;
    end

    always_comb begin
        addr_phase = frame_n_q && !frame_n;
        beat_done  = !irdy_n && !trdy_n;
    end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cont_mode,
    input  logic cancel,
    input  logic ack,
    input  logic addr_phase,
    input  logic hit,
    input  logic beat_done,
    output logic take_addr,
    output logic take_data,
    output logic armed,
    output logic holding
);
    cap_state_t state_q, state_d;
    logic       cont_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cont_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cancel)
                cont_q <= 1'b0;
            else if (state_q == ST_IDLE && arm)
                cont_q <= cont_mode;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_d = ST_ARMED;
            ST_ARMED: begin
                if (cancel)                  state_d = ST_IDLE;
                else if (addr_phase && hit)  state_d = ST_DATA;
            end
            ST_DATA:  if (beat_done) state_d = ST_HOLD;
            ST_HOLD:  if (ack) state_d = (cont_q && !cancel) ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_addr = (state_q == ST_ARMED) && !cancel && addr_phase && hit;
        take_data = (state_q == ST_DATA) && beat_done;
        armed     = (state_q == ST_ARMED);
        holding   = (state_q == ST_HOLD);
    end
endmodule

// File: rtl/cap_record.sv
module cap_record
    import cap_pkg::*;
#(
    parameter int ADW = 32,
    localparam int BEW = ADW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take_addr,
    input  logic           take_data,
    input  logic           rd_src_sel,
    input  logic           frame_n,
    input  logic [ADW-1:0] ad,
    input  logic [BEW-1:0] cbe_n,
    input  logic [ADW-1:0] wr_reg_q,
    input  logic [ADW-1:0] ld_reg_q,
    output logic [3:0]     rec_cmd,
    output logic [ADW-1:0] rec_addr,
    output logic [ADW-1:0] rec_data,
    output logic           rec_data_ok,
    output logic [BEW-1:0] rec_be_n,
    output logic           rec_burst,
    output logic           rec_other
);
    cmd_class_t     cls;
    logic [ADW-1:0] data_sel;
    logic           ok_sel;

    always_comb begin
        cls = classify(rec_cmd);
        unique case (cls)
            CL_WRITE: begin data_sel = ad; ok_sel = 1'b1; end
            CL_READ:  begin data_sel = rd_src_sel ? ld_reg_q : wr_reg_q; ok_sel = 1'b1; end
            default:  begin data_sel = '0; ok_sel = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cmd     <= '0;
            rec_addr    <= '0;
            rec_data    <= '0;
            rec_data_ok <= 1'b0;
            rec_be_n    <= '1;
            rec_burst   <= 1'b0;
            rec_other   <= 1'b0;
        end else begin
            if (take_addr) begin
                rec_cmd  <= cbe_n[3:0];
                rec_addr <= ad;
            end
            if (take_data) begin
                rec_data    <= data_sel;
                rec_data_ok <= ok_sel;
                rec_be_n    <= cbe_n;
                rec_burst   <= !frame_n;
                rec_other   <= (cls == CL_OTHER);
            end
        end
    end
endmodule

// File: rtl/bus_cycle_capture.sv
module bus_cycle_capture #(
    parameter int ADW = 32,
    localparam int BEW = ADW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic           cont_mode,
    input  logic           cancel,
    input  logic           ack,
    input  logic           rd_src_sel,
    input  logic           bus_frame_n,
    input  logic           bus_irdy_n,
    input  logic           bus_trdy_n,
    input  logic [ADW-1:0] bus_ad,
    input  logic [BEW-1:0] bus_cbe_n,
    input  logic           tgt_hit,
    input  logic [ADW-1:0] wr_reg_q,
    input  logic [ADW-1:0] ld_reg_q,
    output logic           armed,
    output logic           cap_valid,
    output logic [3:0]     cap_cmd,
    output logic [ADW-1:0] cap_addr,
    output logic [ADW-1:0] cap_data,
    output logic           cap_data_ok,
    output logic [BEW-1:0] cap_be_n,
    output logic           cap_burst,
    output logic           cap_other
);
    logic addr_phase, beat_done, take_addr, take_data;

    cap_phase_track u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (bus_frame_n),
        .irdy_n     (bus_irdy_n),
        .trdy_n     (bus_trdy_n),
        .addr_phase (addr_phase),
        .beat_done  (beat_done)
    );

    cap_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .cont_mode  (cont_mode),
        .cancel     (cancel),
        .ack        (ack),
        .addr_phase (addr_phase),
        .hit        (tgt_hit),
        .beat_done  (beat_done),
        .take_addr  (take_addr),
        .take_data  (take_data),
        .armed      (armed),
        .holding    (cap_valid)
    );

    cap_record #(.ADW(ADW)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_addr   (take_addr),
        .take_data   (take_data),
        .rd_src_sel  (rd_src_sel),
        .frame_n     (bus_frame_n),
        .ad          (bus_ad),
        .cbe_n       (bus_cbe_n),
        .wr_reg_q    (wr_reg_q),
        .ld_reg_q    (ld_reg_q),
        .rec_cmd     (cap_cmd),
        .rec_addr    (cap_addr),
        .rec_data    (cap_data),
        .rec_data_ok (cap_data_ok),
        .rec_be_n    (cap_be_n),
        .rec_burst   (cap_burst),
        .rec_other   (cap_other)
    );
endmodule

// File: rtl/bus_cycle_capture_chk.sv
module bus_cycle_capture_chk #(
    parameter int ADW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cancel,
    input logic           ack,
    input logic           armed,
    input logic           cap_valid,
    input logic [3:0]     cap_cmd,
    input logic [ADW-1:0] cap_addr,
    input logic [ADW-1:0] cap_data,
    input logic           cap_data_ok
);
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed, cap_valid})); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && !ack |=> cap_valid && $stable(cap_addr) && $stable(cap_cmd) && $stable(cap_data)); // R10

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && ack |=> !cap_valid); // R10

    AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cancel |=> !armed && !cap_valid); // R12

    AST_CFG_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && (cap_cmd == 4'hA || cap_cmd == 4'hB) |-> !cap_data_ok && cap_data == '0); // R7

    AST_RW_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid && (cap_cmd == 4'h2 || cap_cmd == 4'h3 || cap_cmd == 4'h6 || cap_cmd == 4'h7)
        |-> cap_data_ok); // R5
endmodule

bind bus_cycle_capture bus_cycle_capture_chk #(.ADW(ADW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cancel      (cancel),
    .ack         (ack),
    .armed       (armed),
    .cap_valid   (cap_valid),
    .cap_cmd     (cap_cmd),
    .cap_addr    (cap_addr),
    .cap_data    (cap_data),
    .cap_data_ok (cap_data_ok)
);

// File: tb/tb_bus_cycle_capture.sv
module tb_bus_cycle_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, cont_mode = 1'b0, cancel = 1'b0, ack = 1'b0, rd_src_sel = 1'b0;
    logic        bus_frame_n = 1'b1, bus_irdy_n = 1'b1, bus_trdy_n = 1'b1, tgt_hit = 1'b0;
    logic [31:0] bus_ad = '0;
    logic [3:0]  bus_cbe_n = 4'hF;
    logic [31:0] wr_reg_q = 32'h0000_00AA;
    logic [31:0] ld_reg_q = 32'h1234_5678;
    logic        armed, cap_valid, cap_data_ok, cap_burst, cap_other;
    logic [3:0]  cap_cmd, cap_be_n;
    logic [31:0] cap_addr, cap_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_cycle_capture dut (.*);

    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        sel;
        logic [31:0] exp_data;
        logic        exp_ok;
        logic        exp_oth;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'h3, 32'h0000_0160, 4'b1110, 32'h0000_00AA, 1'b0, 32'h0000_00AA, 1'b1, 1'b0},
        '{4'h7, 32'h000D_4000, 4'b0000, 32'hCAFE_0055, 1'b1, 32'hCAFE_0055, 1'b1, 1'b0},
        '{4'h2, 32'h0000_0160, 4'b1110, 32'hDEAD_BEEF, 1'b0, 32'h0000_00AA, 1'b1, 1'b0},
        '{4'h6, 32'h000D_4000, 4'b1100, 32'hDEAD_BEEF, 1'b1, 32'h1234_5678, 1'b1, 1'b0},
        '{4'h6, 32'h000D_4004, 4'b0011, 32'hDEAD_BEEF, 1'b0, 32'h0000_00AA, 1'b1, 1'b0},
        '{4'hA, 32'h0001_0800, 4'b0000, 32'h5555_5555, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        '{4'hB, 32'h0001_0804, 4'b0000, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b0, 1'b0},
        '{4'hC, 32'h0000_2000, 4'b1011, 32'h7777_7777, 1'b0, 32'h0000_0000, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_arm(input logic cont);
        @(negedge clk); arm = 1'b1; cont_mode = cont;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_cancel();
        @(negedge clk); cancel = 1'b1;
        @(negedge clk); cancel = 1'b0;
    endtask

    // Drives one transaction; returns at the negedge after the bus goes idle,
    // which is the first sample point where the record is valid.
    task automatic bus_txn(input logic [3:0] cmd, input logic [31:0] addr,
                           input logic [3:0] be, input logic [31:0] wd,
                           input logic burst, input logic hit, input logic cxl);
        @(negedge clk);
        bus_frame_n = 1'b0; bus_ad = addr; bus_cbe_n = cmd; tgt_hit = hit;
        cancel = cxl;
        @(negedge clk);
        cancel = 1'b0; tgt_hit = 1'b0;
        bus_ad = wd; bus_cbe_n = be; bus_irdy_n = 1'b0; bus_trdy_n = 1'b0;
        bus_frame_n = burst ? 1'b0 : 1'b1;
        if (burst) begin
            @(negedge clk);
            bus_ad = wd ^ 32'hFFFF_FFFF; bus_cbe_n = ~be; bus_frame_n = 1'b1;
        end
        @(negedge clk);
        bus_frame_n = 1'b1; bus_irdy_n = 1'b1; bus_trdy_n = 1'b1;
        bus_cbe_n = 4'hF; bus_ad = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 armed after reset", {31'd0, armed}, 32'd0);
        chk("R1 valid after reset", {31'd0, cap_valid}, 32'd0);

        // R2: not armed -> nothing captured
        bus_txn(4'h3, 32'h150, 4'b1110, 32'h11, 1'b0, 1'b1, 1'b0);
        chk("R2 unarmed no capture", {31'd0, cap_valid}, 32'd0);

        // Vector table walk (R4 R5 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            rd_src_sel = VECS[i].sel;
            pulse_arm(1'b0);
            chk("R2 armed after arm", {31'd0, armed}, 32'd1);
            bus_txn(VECS[i].cmd, VECS[i].addr, VECS[i].be, VECS[i].wdata, 1'b0, 1'b1, 1'b0);
            chk("R4 valid", {31'd0, cap_valid}, 32'd1);
            chk("R4 cmd", {28'd0, cap_cmd}, {28'd0, VECS[i].cmd});
            chk("R4 addr", cap_addr, VECS[i].addr);
            chk("R4 be_n", {28'd0, cap_be_n}, {28'd0, VECS[i].be});
            chk("R5/R6/R7 data", cap_data, VECS[i].exp_data);
            chk("R5/R6/R7 data_ok", {31'd0, cap_data_ok}, {31'd0, VECS[i].exp_ok});
            chk("R8 other flag", {31'd0, cap_other}, {31'd0, VECS[i].exp_oth});
            chk("R9 single not burst", {31'd0, cap_burst}, 32'd0);
            pulse_ack();
            chk("R10 single ack idle valid", {31'd0, cap_valid}, 32'd0);
            chk("R10 single ack idle armed", {31'd0, armed}, 32'd0);
        end

        // R3: hit low ignored
        pulse_arm(1'b0);
        bus_txn(4'h3, 32'h999, 4'b1110, 32'h1, 1'b0, 1'b0, 1'b0);
        chk("R3 no-hit no capture", {31'd0, cap_valid}, 32'd0);
        chk("R3 no-hit stays armed", {31'd0, armed}, 32'd1);
        pulse_cancel();
        chk("R11 cancel disarms", {31'd0, armed}, 32'd0);

        // R9: burst, only first beat recorded
        rd_src_sel = 1'b0;
        pulse_arm(1'b0);
        bus_txn(4'h7, 32'h000D_4010, 4'b0000, 32'hA5A5_0001, 1'b1, 1'b1, 1'b0);
        chk("R9 burst flag", {31'd0, cap_burst}, 32'd1);
        chk("R9 first beat data", cap_data, 32'hA5A5_0001);
        chk("R9 first beat be", {28'd0, cap_be_n}, 32'd0);

        // R10: new cycle while holding is ignored
        bus_txn(4'h3, 32'h0000_0333, 4'b1110, 32'h33, 1'b0, 1'b1, 1'b0);
        chk("R10 held addr", cap_addr, 32'h000D_4010);
        chk("R10 held cmd", {28'd0, cap_cmd}, 32'h7);
        pulse_ack();

        // R11: continuous mode
        pulse_arm(1'b1);
        bus_txn(4'h3, 32'h0000_0160, 4'b1110, 32'h0000_0042, 1'b0, 1'b1, 1'b0);
        chk("R11 cont first capture", cap_addr, 32'h0000_0160);
        pulse_ack();
        chk("R11 cont rearmed", {31'd0, armed}, 32'd1);
        bus_txn(4'h2, 32'h0000_0164, 4'b1101, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0);
        chk("R11 cont second addr", cap_addr, 32'h0000_0164);
        chk("R11 cont second data", cap_data, 32'h0000_00AA);
        pulse_cancel();
        pulse_ack();
        chk("R11 cancel ends cont", {31'd0, armed}, 32'd0);
        bus_txn(4'h3, 32'h0000_0168, 4'b1110, 32'h5, 1'b0, 1'b1, 1'b0);
        chk("R11 no capture after cancel", {31'd0, cap_valid}, 32'd0);

        // R12: cancel and hit address phase in the same cycle
        pulse_arm(1'b0);
        bus_txn(4'h3, 32'h0000_0170, 4'b1110, 32'h9, 1'b0, 1'b1, 1'b1);
        chk("R12 cancel wins valid", {31'd0, cap_valid}, 32'd0);
        chk("R12 cancel wins armed", {31'd0, armed}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule